// File: doc/BRIEF.md
# GDDR3 Write Burst Sequencer

This block sits on the controller side of a graphics DRAM channel. It takes requests one at a time over a ready/valid handshake and turns them into commands on the DRAM command pins. A request is a WRITE, a READ or a PRECHARGE. It carries a bank, a column, an auto-precharge flag and, for a WRITE, four data words. For each WRITE it sends the four words as one burst, a write latency after the command. The burst goes on two data half-slots per clock, framed by a write strobe that has a half-cycle preamble and a half-cycle postamble.

The data path is single-clock. Each clock carries a first-half and a second-half value for the data and for the strobe, and a later double-rate output stage serialises them. The sequencer delays a request, by holding its ready low, until the spacing rules allow it:
- A WRITE may not cut into the previous burst or its strobe window.
- A READ waits for the write-to-read delay after the last burst.
- A PRECHARGE to a bank waits for write recovery after that bank's last burst.

Write recovery is tracked per bank, so a PRECHARGE waiting on one bank does not delay traffic to the others. Row activation, refresh, read data capture and training are handled elsewhere.

Top module: `gwr_burst_seq`

## Requirements
- R1: During reset and in every cycle without a command, the pins show NOP: cs_n=0, ras_n=1, cas_n=1, we_n=1, with addr=0, ba=0, dq_oe=0 and wdqs_en=2'b00. cke is always 1.
- R2: Request kinds are encoded on req_kind as 0 for WRITE, 1 for READ and 2 for PRECHARGE. The command pins are:
  - WRITE: cs_n=0, ras_n=1, cas_n=0, we_n=0.
  - READ: cs_n=0, ras_n=1, cas_n=0, we_n=1.
  - PRECHARGE: cs_n=0, ras_n=0, cas_n=1, we_n=0.
- R3: For WRITE and READ, addr[7:0]=col[7:0], addr[9]=col[8], addr[8]=the auto-precharge flag and addr[11:10]=0. For PRECHARGE, addr is 0. ba carries the request's bank for all three kinds.
- R4: A request accepted on a rising edge shows its command in the clock cycle that follows. Requests issue in order, each in the earliest cycle its spacing rules allow.
- R5: Two WRITE commands are at least 3 cycles apart, and a WRITE is never held off once 3 cycles have passed since the last WRITE.
- R6: For a WRITE command in cycle c, dq_oe is high in cycles c+WL and c+WL+1. In those two cycles, dq_h0/dq_h1 carry elements 0/1 and then 2/3, where element k is req_data[k*DW +: DW].
- R7: The strobe is described by wdqs_en and wdqs_lvl, where bit 0 is the first half of the clock and bit 1 the second. The strobe pattern for a WRITE command in cycle c is:
  - Preamble, cycle c+WL-1: en=2'b10, lvl=2'b00.
  - Each data cycle: en=2'b11, lvl=2'b01.
  - Postamble, cycle c+WL+2: en=2'b01, lvl=2'b00.
  The strobe windows of two bursts never share a half-cycle.
- R8: A READ issues no earlier than cycle c+WL+2+TWTR, where c is the cycle of the last WRITE.
- R9: A PRECHARGE to bank b issues no earlier than cycle c+WL+2+TWR, where c is the cycle of the last WRITE to bank b. Writes to other banks do not delay it.
- R10: Outside burst data cycles, dq_oe is 0 and dq_h0, dq_h1 and wdqs_lvl are 0. READ and PRECHARGE requests start no burst. req_data has no effect except on an accepted WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 0 WRITE, 1 READ, 2 PRECHARGE, 3 no operation |
| req_bank | input | BA_W | Target bank |
| req_col | input | 9 | Starting column |
| req_ap | input | 1 | Auto-precharge after the burst |
| req_data | input | 4*DW | Four burst elements, element 0 in the low bits |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 12 | Address pins |
| ba | output | BA_W | Bank address pins |
| dq_h0 | output | DW | Data for the first half of the clock |
| dq_h1 | output | DW | Data for the second half of the clock |
| dq_oe | output | 1 | Data driven in this clock |
| wdqs_en | output | 2 | Strobe driven, per half-cycle |
| wdqs_lvl | output | 2 | Strobe level, per half-cycle |

## Verification
A command is due in the cycle after the edge that accepts its request. The bench computes that cycle as the later of the cycle after the offer and the bound set by the spacing rules, using the bench's own record of past WRITE cycles.

Burst results are scheduled from the observed command cycle c: the preamble at c+WL-1, the data at c+WL and c+WL+1, and the postamble at c+WL+2. The bench samples every output on the falling edge. It compares data and strobe in every cycle against a per-cycle table of expected values. The table also flags any half-cycle that two bursts would both claim.

// File: rtl/wseq_pkg.sv
`timescale 1ns/1ps
package wseq_pkg;

  typedef enum logic [1:0] {
    RQ_WRITE = 2'd0,
    RQ_READ  = 2'd1,
    RQ_PRE   = 2'd2,
    RQ_NONE  = 2'd3
  } req_kind_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned COL_W     = 9;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned BURST_CYC = BURST_LEN / 2;
  localparam pins_t       PINS_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  // cycles between two WRITE commands: burst plus one slot for pre/postamble
  function automatic int unsigned gap_wr_wr();
    return BURST_CYC + 1;
  endfunction

  // WRITE command to READ command, counted from the command cycle
  function automatic int unsigned gap_wr_rd(int unsigned wl, int unsigned twtr);
    return wl + BURST_CYC + twtr;
  endfunction

  // WRITE command to PRECHARGE of the same bank
  function automatic int unsigned gap_wr_pre(int unsigned wl, int unsigned twr);
    return wl + BURST_CYC + twr;
  endfunction

  function automatic pins_t pins_for(req_kind_e k);
    pins_t p;
    p = PINS_NOP;
    case (k)
      RQ_WRITE: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
      RQ_READ:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
      RQ_PRE:   p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      default:  p = PINS_NOP;
    endcase
    return p;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_for(req_kind_e k, logic [COL_W-1:0] col, logic ap);
    logic [ADDR_W-1:0] a;
    a = '0;
    if (k == RQ_WRITE || k == RQ_READ) begin
      a[7:0] = col[7:0];
      a[8]   = ap;
      a[9]   = col[8];
    end
    return a;
  endfunction

endpackage

// File: rtl/wseq_holdoff.sv
`timescale 1ns/1ps
module wseq_holdoff #(
  parameter int unsigned LOAD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic clear
);
  localparam int unsigned CW = $clog2(LOAD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (arm)        cnt <= CW'(LOAD);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign clear = (cnt == '0);
endmodule

// File: rtl/wseq_spacing.sv
`timescale 1ns/1ps
module wseq_spacing
  import wseq_pkg::*;
#(
  parameter int unsigned WL    = 5,
  parameter int unsigned TWR   = 4,
  parameter int unsigned TWTR  = 3,
  parameter int unsigned BA_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_fire,
  input  logic [BA_W-1:0]         wr_bank,
  output logic                    wr_ok,
  output logic                    rd_ok,
  output logic [(1<<BA_W)-1:0]    pre_ok
);
  localparam int unsigned NBANK = 1 << BA_W;
  localparam int unsigned LD_WW = gap_wr_wr() - 1;
  localparam int unsigned LD_WR = gap_wr_rd(WL, TWTR) - 1;
  localparam int unsigned LD_WP = gap_wr_pre(WL, TWR) - 1;

  wseq_holdoff #(.LOAD(LD_WW)) ww_i (.clk(clk), .rst_n(rst_n), .arm(wr_fire), .clear(wr_ok));
  wseq_holdoff #(.LOAD(LD_WR)) wr_i (.clk(clk), .rst_n(rst_n), .arm(wr_fire), .clear(rd_ok));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_arm;
    assign bank_arm = wr_fire && (wr_bank == BA_W'(b));
    wseq_holdoff #(.LOAD(LD_WP)) wp_i (
      .clk(clk), .rst_n(rst_n), .arm(bank_arm), .clear(pre_ok[b])
    );
  end
endmodule

// File: rtl/wseq_cmd_reg.sv
`timescale 1ns/1ps
module wseq_cmd_reg
  import wseq_pkg::*;
#(
  parameter int unsigned BA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  req_kind_e         kind,
  input  logic [BA_W-1:0]   bank,
  input  logic [COL_W-1:0]  col,
  input  logic              ap,
  output pins_t             pins_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BA_W-1:0]   ba_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= PINS_NOP;
      addr_q <= '0;
      ba_q   <= '0;
    end else if (fire && kind != RQ_NONE) begin
      pins_q <= pins_for(kind);
      addr_q <= addr_for(kind, col, ap);
      ba_q   <= bank;
    end else begin
      pins_q <= PINS_NOP;
      addr_q <= '0;
      ba_q   <= '0;
    end
  end
endmodule

// File: rtl/wseq_burst_pipe.sv
`timescale 1ns/1ps
module wseq_burst_pipe
  import wseq_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned WL = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     launch,
  input  logic [BURST_LEN*DW-1:0]  launch_data,
  output logic [DW-1:0]            dq_h0,
  output logic [DW-1:0]            dq_h1,
  output logic                     dq_oe,
  output logic [1:0]               wdqs_en,
  output logic [1:0]               wdqs_lvl,
  output logic                     ev_pre,
  output logic                     ev_d0,
  output logic                     ev_d1,
  output logic                     ev_post
);
  // stage k valid: a WRITE command was on the pins k cycles ago
  localparam int unsigned NST = WL + BURST_CYC + 1;
  localparam int unsigned DST = WL + 1;

  logic [NST-1:0]            vld;
  logic [BURST_LEN*DW-1:0]   dat [DST];
  logic [2*DW-1:0]           tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= {vld[NST-2:0], launch};
  end

  always_ff @(posedge clk) begin
    if (launch) dat[0] <= launch_data;
    for (int k = 1; k < DST; k++) dat[k] <= dat[k-1];
    tail_q <= dat[WL][BURST_LEN*DW-1:2*DW];
  end

  assign ev_pre  = vld[WL-1];
  assign ev_d0   = vld[WL];
  assign ev_d1   = vld[WL+1];
  assign ev_post = vld[WL+2];

  assign dq_oe = ev_d0 | ev_d1;

  always_comb begin
    dq_h0 = '0;
    dq_h1 = '0;
    if (ev_d0) begin
      dq_h0 = dat[WL][0 +: DW];
      dq_h1 = dat[WL][DW +: DW];
    end else if (ev_d1) begin
      dq_h0 = tail_q[0 +: DW];
      dq_h1 = tail_q[DW +: DW];
    end
  end

  // bit 0 first half, bit 1 second half; high in first half gives the rising edge
  assign wdqs_en  = {ev_pre | dq_oe, ev_post | dq_oe};
  assign wdqs_lvl = {1'b0, dq_oe};
endmodule

// File: rtl/gwr_burst_seq.sv
`timescale 1ns/1ps
module gwr_burst_seq
  import wseq_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned WL   = 5,
  parameter int unsigned TWR  = 4,
  parameter int unsigned TWTR = 3,
  parameter int unsigned BA_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_kind,
  input  logic [BA_W-1:0]          req_bank,
  input  logic [8:0]               req_col,
  input  logic                     req_ap,
  input  logic [4*DW-1:0]          req_data,
  output logic                     cke,
  output logic                     cs_n,
  output logic                     ras_n,
  output logic                     cas_n,
  output logic                     we_n,
  output logic [11:0]              addr,
  output logic [BA_W-1:0]          ba,
  output logic [DW-1:0]            dq_h0,
  output logic [DW-1:0]            dq_h1,
  output logic                     dq_oe,
  output logic [1:0]               wdqs_en,
  output logic [1:0]               wdqs_lvl
);
  localparam int unsigned NBANK = 1 << BA_W;

  req_kind_e         kind;
  logic              wr_ok, rd_ok, kind_ok, fire, wr_fire;
  logic [NBANK-1:0]  pre_ok;
  pins_t             pins_q;
  logic              ev_pre, ev_d0, ev_d1, ev_post;

  assign kind = req_kind_e'(req_kind);

  always_comb begin
    case (kind)
      RQ_WRITE: kind_ok = wr_ok;
      RQ_READ:  kind_ok = rd_ok;
      RQ_PRE:   kind_ok = pre_ok[req_bank];
      default:  kind_ok = 1'b1;
    endcase
  end

  assign req_ready = kind_ok;
  assign fire      = req_valid & kind_ok;
  assign wr_fire   = fire & (kind == RQ_WRITE);

  wseq_spacing #(.WL(WL), .TWR(TWR), .TWTR(TWTR), .BA_W(BA_W)) spacing_i (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_bank(req_bank),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .pre_ok(pre_ok)
  );

  wseq_cmd_reg #(.BA_W(BA_W)) cmd_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .kind(kind), .bank(req_bank),
    .col(req_col), .ap(req_ap), .pins_q(pins_q), .addr_q(addr), .ba_q(ba)
  );

  wseq_burst_pipe #(.DW(DW), .WL(WL)) pipe_i (
    .clk(clk), .rst_n(rst_n), .launch(wr_fire), .launch_data(req_data),
    .dq_h0(dq_h0), .dq_h1(dq_h1), .dq_oe(dq_oe),
    .wdqs_en(wdqs_en), .wdqs_lvl(wdqs_lvl),
    .ev_pre(ev_pre), .ev_d0(ev_d0), .ev_d1(ev_d1), .ev_post(ev_post)
  );

  assign cke   = 1'b1;
  assign cs_n  = pins_q.cs_n;
  assign ras_n = pins_q.ras_n;
  assign cas_n = pins_q.cas_n;
  assign we_n  = pins_q.we_n;
endmodule

// File: rtl/gwr_burst_seq_chk.sv
`timescale 1ns/1ps
module gwr_burst_seq_chk #(
  parameter int unsigned DW   = 16,
  parameter int unsigned WL   = 5,
  parameter int unsigned TWR  = 4,
  parameter int unsigned TWTR = 3,
  parameter int unsigned BA_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_fire,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] ba,
  input logic [DW-1:0]   dq_h0,
  input logic [DW-1:0]   dq_h1,
  input logic            dq_oe,
  input logic [1:0]      wdqs_en,
  input logic [1:0]      wdqs_lvl,
  input logic            ev_pre,
  input logic            ev_d0,
  input logic            ev_d1,
  input logic            ev_post
);
  localparam int unsigned NBANK = 1 << BA_W;
  localparam int unsigned SAT   = WL + TWR + TWTR + 8;

  logic is_wr, is_rd, is_pre;
  assign is_wr  = !cs_n &&  ras_n && !cas_n && !we_n;
  assign is_rd  = !cs_n &&  ras_n && !cas_n &&  we_n;
  assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;

  int unsigned since_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             since_wr <= SAT;
    else if (is_wr)         since_wr <= 1;
    else if (since_wr < SAT) since_wr <= since_wr + 1;
  end

  // R4
  wr_cmd_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> is_wr);

  // R5
  wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> (!$past(is_wr) && !$past(is_wr, 2)));

  // R6
  burst_second_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_d0 |=> (ev_d1 && dq_oe));

  // R6
  pre_leads_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pre |=> ev_d0);

  // R7
  preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(wdqs_en[1]) && !$past(wdqs_lvl[1])));

  // R7
  postamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (wdqs_en[0] && !wdqs_lvl[0]));

  // R7
  post_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_d1 |=> ev_post);

  // R8
  rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> (since_wr >= WL + 2 + TWTR));

  // R10
  quiet_dq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_h0 == '0 && dq_h1 == '0));

  for (genvar b = 0; b < NBANK; b++) begin : g_bk
    int unsigned since_bk;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              since_bk <= SAT;
      else if (is_wr && ba == BA_W'(b))        since_bk <= 1;
      else if (since_bk < SAT)                 since_bk <= since_bk + 1;
    end
    // R9
    pre_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pre && ba == BA_W'(b)) |-> (since_bk >= WL + 2 + TWR));
  end
endmodule

bind gwr_burst_seq gwr_burst_seq_chk #(
  .DW(DW), .WL(WL), .TWR(TWR), .TWTR(TWTR), .BA_W(BA_W)
) chk_i (.*);

// File: tb/gwr_burst_seq_tb_top.sv
`timescale 1ns/1ps
module gwr_burst_seq_tb_top;
  localparam int DW = 8, WL = 3, TWR = 2, TWTR = 2, BA_W = 2;
  localparam int K_WR = 0, K_RD = 1, K_PRE = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_ap;
  logic [1:0] req_kind;
  logic [BA_W-1:0] req_bank;
  logic [8:0] req_col;
  logic [4*DW-1:0] req_data;
  logic cke, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [11:0] addr;
  logic [BA_W-1:0] ba;
  logic [DW-1:0] dq_h0, dq_h1;
  logic [1:0] wdqs_en, wdqs_lvl;

  gwr_burst_seq #(.DW(DW), .WL(WL), .TWR(TWR), .TWTR(TWTR), .BA_W(BA_W)) dut_i (.*);

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // expected request queue
  int q_kind[256], q_bank[256], q_col[256], q_ap[256], q_offer[256];
  logic [31:0] q_data[256];
  int q_wr = 0, q_rd = 0;
  int last_wr = -100;
  int last_bk[4] = '{-100, -100, -100, -100};

  // expected per-cycle burst table
  logic [1:0] e_en[64], e_lvl[64];
  logic e_oe[64];
  logic [7:0] e_d0[64], e_d1[64];
  initial for (int i = 0; i < 64; i++) begin
    e_en[i] = 0; e_lvl[i] = 0; e_oe[i] = 0; e_d0[i] = 0; e_d1[i] = 0;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic schedule(input int c, input logic [31:0] d);
    int s;
    s = (c + WL - 1) % 64;
    chk(!e_en[s][1], "R7", "preamble half already claimed", e_en[s], 0);
    e_en[s][1] = 1'b1;
    s = (c + WL) % 64;
    chk(e_en[s] == 0, "R7", "data cycle 0 window overlap", e_en[s], 0);
    e_en[s] = 2'b11; e_lvl[s] = 2'b01; e_oe[s] = 1; e_d0[s] = d[7:0]; e_d1[s] = d[15:8];
    s = (c + WL + 1) % 64;
    chk(e_en[s] == 0, "R7", "data cycle 1 window overlap", e_en[s], 0);
    e_en[s] = 2'b11; e_lvl[s] = 2'b01; e_oe[s] = 1; e_d0[s] = d[23:16]; e_d1[s] = d[31:24];
    s = (c + WL + 2) % 64;
    chk(!e_en[s][0], "R7", "postamble half already claimed", e_en[s], 0);
    e_en[s][0] = 1'b1;
  endtask

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] pins;
      int s;
      pins = {cs_n, ras_n, cas_n, we_n};
      chk(cke == 1'b1, "R1", "cke", cke, 1);
      if (pins != 4'b0111) begin
        if (q_rd == q_wr) chk(0, "R4", "unexpected command", pins, 4'b0111);
        else begin
          int k, b, bound, expc;
          logic [3:0] ep;
          logic [11:0] ea;
          k = q_kind[q_rd % 256]; b = q_bank[q_rd % 256];
          ep = (k == K_WR) ? 4'b0100 : (k == K_RD) ? 4'b0101 : 4'b0010;
          chk(pins == ep, "R2", "command pins", pins, ep);
          ea = 0;
          if (k != K_PRE) begin
            ea[7:0] = q_col[q_rd % 256][7:0];
            ea[8]   = q_ap[q_rd % 256][0];
            ea[9]   = q_col[q_rd % 256][8];
          end
          chk(addr == ea, "R3", "address pins", addr, ea);
          chk(ba == b[BA_W-1:0], "R3", "bank pins", ba, b);
          bound = (k == K_WR) ? last_wr + 3 :
                  (k == K_RD) ? last_wr + WL + 2 + TWTR : last_bk[b] + WL + 2 + TWR;
          expc = (q_offer[q_rd % 256] + 1 > bound) ? q_offer[q_rd % 256] + 1 : bound;
          if (k == K_WR)      chk(cyc == expc, "R5", "write issue cycle", cyc, expc);
          else if (k == K_RD) chk(cyc == expc, "R8", "read issue cycle", cyc, expc);
          else                chk(cyc == expc, "R9", "precharge issue cycle", cyc, expc);
          if (k == K_WR) begin
            last_wr = cyc; last_bk[b] = cyc;
            schedule(cyc, q_data[q_rd % 256]);
          end
          q_rd++;
        end
      end else begin
        chk(addr == 0 && ba == 0, "R1", "idle address/bank", {addr, ba}, 0);
      end
      s = cyc % 64;
      chk(dq_oe == e_oe[s] && dq_h0 == e_d0[s] && dq_h1 == e_d1[s],
          e_oe[s] ? "R6" : "R10", "data oe/h0/h1", {dq_oe, dq_h0, dq_h1},
          {e_oe[s], e_d0[s], e_d1[s]});
      chk(wdqs_en == e_en[s] && wdqs_lvl == e_lvl[s], "R7", "strobe en/lvl",
          {wdqs_en, wdqs_lvl}, {e_en[s], e_lvl[s]});
      e_en[s] = 0; e_lvl[s] = 0; e_oe[s] = 0; e_d0[s] = 0; e_d1[s] = 0;
    end
  end

  // called at posedge+1; returns at posedge+1 of the command cycle
  task automatic send(input int k, input int b, input int col, input bit ap,
                      input logic [31:0] d);
    bit acc;
    req_valid = 1; req_kind = 2'(k); req_bank = BA_W'(b);
    req_col = 9'(col); req_ap = ap; req_data = d;
    q_kind[q_wr % 256] = k; q_bank[q_wr % 256] = b; q_col[q_wr % 256] = col;
    q_ap[q_wr % 256] = int'(ap); q_data[q_wr % 256] = d; q_offer[q_wr % 256] = cyc;
    q_wr++;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
    end while (!acc);
    req_valid = 0;
  endtask

  // R10: data and strobe-related inputs wiggle while no request is offered
  task automatic idle(input int n);
    req_valid = 0;
    for (int i = 0; i < n; i++) begin
      req_data = {8'(i * 29 + 1), 8'(i * 7), 8'hA5, 8'(i)};
      req_kind = 2'(K_WR);
      @(posedge clk); #1;
    end
  endtask

  function automatic logic [31:0] mk(input int a);
    return {8'(a * 13 + 8), 8'(a * 13 + 6), 8'(a * 13 + 4), 8'(a * 13 + 2)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
    end
  end

  initial begin
    int n;
    n = 0;
    rst_n = 0; req_valid = 0; req_kind = 0; req_bank = 0; req_col = 0; req_ap = 0;
    req_data = 32'hDEADBEEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "reset pins",
        {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(dq_oe == 0 && wdqs_en == 0 && addr == 0, "R1", "reset data/strobe/addr",
        {dq_oe, wdqs_en, addr}, 0);
    @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;

    // single write, then quiet
    send(K_WR, 0, 9'h1A5, 0, 32'h44332211); idle(12);
    // back-to-back writes, all banks, auto-precharge alternating
    for (int i = 0; i < 4; i++) begin send(K_WR, i, 9'h100 + i * 7, i[0], mk(n)); n++; end
    idle(12);
    // write then read
    send(K_WR, 1, 9'h0F3, 1, mk(n)); n++; send(K_RD, 1, 9'h155, 0, 32'hFFFFFFFF); idle(4);
    // write then precharge same bank
    send(K_WR, 2, 9'h022, 0, mk(n)); n++; send(K_PRE, 2, 9'h1FF, 1, 32'h12345678); idle(3);
    // precharge to an idle bank is not delayed by a write to another bank
    send(K_WR, 3, 9'h0AA, 0, mk(n)); n++; send(K_PRE, 0, 0, 0, 0); send(K_PRE, 3, 0, 0, 0);
    idle(12);
    // sweep of kinds, banks and gaps
    for (int g = 0; g < 4; g++) begin
      for (int i = 0; i < 12; i++) begin
        int k;
        k = (i % 4 == 3) ? K_RD : (i % 4 == 2) ? K_PRE : K_WR;
        send(k, (i * 3 + g) % 4, (i * 37 + g * 11) % 512, i[1] ^ g[0], mk(n)); n++;
        idle((i + g) % 4);
      end
    end
    idle(20);
    chk(q_rd == q_wr, "R4", "all requests issued", q_rd, q_wr);
    done = 1;
    finish_run();
  end
endmodule